// File: doc/BRIEF.md
# Isolated Page Access Guard

This block sits in the memory access path. It decides whether a load or store may go ahead, based on the page it touches. Each request carries a virtual address, a load/store flag and a flag that marks a secure move instruction. The guard looks up the page's translation entry in a small, fully associative cache. It then returns either a physical address or a fault code.

The check works in both directions. Ordinary memory instructions may not touch pages marked isolated. The secure move may not touch pages that are not marked. Apart from this check, secure moves use the same translation as ordinary accesses.

An external walker fills the cache. When a lookup misses, the guard returns a miss with no fault so that the walker can supply the entry through the fill port. The isolation mark of a cached entry is sticky: a refill cannot clear it. Only an unmap (invalidate) of the entry removes it.

Top module: `iso_access_guard`

## Requirements
- R1: When `req_valid` is high at a rising edge, `rsp_valid` is high for exactly the next cycle and carries the result of that request. A new request may arrive on every cycle. `rsp_valid` is low after a cycle with no request.
- R2: A request whose virtual page number (`req_vaddr[47:12]`) matches no valid entry returns `rsp_hit`=0, `rsp_fault`=2'b00 and `rsp_paddr`=0.
- R3: An ordinary access (`req_secure`=0) to an entry whose PTE bit 52 is set returns fault 2'b01 and `rsp_paddr`=0.
- R4: A secure access (`req_secure`=1) to an entry whose PTE bit 52 is clear returns fault 2'b10 and `rsp_paddr`=0.
- R5: An ordinary access to an ordinary page, or a secure access to an isolated page, on a present page with no write violation, returns fault 2'b00 and `rsp_paddr` = {PTE[51:12], req_vaddr[11:0]}. Loads and stores translate the same way.
- R6: When no isolation violation applies, a page with PTE bit 0 (present) clear, or a store to a page with PTE bit 1 (writable) clear, returns fault 2'b11 and `rsp_paddr`=0.
- R7: An isolation violation (2'b01 or 2'b10) is reported in place of the standard fault 2'b11 when both apply.
- R8: A fill whose page number matches a valid entry that has bit 52 set keeps bit 52 set, even when the filled PTE has it clear. All other PTE fields take the new values.
- R9: An invalidate of a page removes its entry, so later lookups of that page miss. A fill made after that takes bit 52 exactly as supplied.
- R10: The cache holds 8 entries. A fill for a page not yet cached takes the slot chosen by a round-robin pointer, which starts at slot 0 after reset. The ninth new page therefore evicts the first one.
- R11: After reset the cache is empty and `rsp_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request present |
| req_vaddr | input | 48 | Virtual address |
| req_store | input | 1 | 1 = store, 0 = load |
| req_secure | input | 1 | 1 = secure move instruction |
| fill_valid | input | 1 | PTE fill present |
| fill_vpn | input | 36 | Page number of the fill |
| fill_pte | input | 64 | PTE to be cached |
| inval_valid | input | 1 | Unmap request present |
| inval_vpn | input | 36 | Page number to unmap |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Page found in the cache |
| rsp_paddr | output | 52 | Physical address, 0 on miss or fault |
| rsp_fault | output | 2 | Fault code |

## Verification
Every response is registered once, so it is due one cycle after the rising edge that accepts the request. Fills and unmaps act at the edge where they are presented and are seen by any request accepted at a later edge. The bench drives all inputs on the falling edge. It reads a response at the next falling edge, which is half a cycle after the edge that registered it. In the back-to-back case it checks each response in its own cycle.

// File: rtl/iso_guard_pkg.sv
package iso_guard_pkg;
  localparam int PTE_W    = 64;
  localparam int ISO_BIT  = 52;
  localparam int PRES_BIT = 0;
  localparam int WR_BIT   = 1;

  typedef enum logic [1:0] {
    FLT_NONE         = 2'b00,
    FLT_PLAIN_ON_ISO = 2'b01,
    FLT_SEC_ON_PLAIN = 2'b10,
    FLT_STD          = 2'b11
  } fault_e;

  // isolation exclusion first, then present / writable
  function automatic fault_e judge(input logic [PTE_W-1:0] pte,
                                   input logic secure, input logic store);
    logic iso;
    iso = pte[ISO_BIT];
    if (iso && !secure)                         return FLT_PLAIN_ON_ISO;
    if (!iso && secure)                         return FLT_SEC_ON_PLAIN;
    if (!pte[PRES_BIT] || (store && !pte[WR_BIT])) return FLT_STD;
    return FLT_NONE;
  endfunction

  // refill merge: a set isolation mark survives when asked to keep it
  function automatic logic [PTE_W-1:0] merge_pte(input logic [PTE_W-1:0] newp,
                                                 input logic keep_iso);
    logic [PTE_W-1:0] r;
    r = newp;
    r[ISO_BIT] = newp[ISO_BIT] | keep_iso;
    return r;
  endfunction
endpackage

// File: rtl/iso_xlat_cache.sv
module iso_xlat_cache
  import iso_guard_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 36
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VPN_W-1:0] lk_vpn,
  output logic             lk_hit,
  output logic [PTE_W-1:0] lk_pte,
  input  logic             fill_valid,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PTE_W-1:0] fill_pte,
  input  logic             inval_valid,
  input  logic [VPN_W-1:0] inval_vpn
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] ent_vld;
  logic [VPN_W-1:0]   ent_vpn [ENTRIES];
  logic [PTE_W-1:0]   ent_pte [ENTRIES];
  logic [IDX_W-1:0]   rr_ptr;

  logic [ENTRIES-1:0] lk_match, fill_match, inval_match, alloc_here;
  logic               fill_any;

  assign fill_any = |fill_match;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    assign lk_match[i]    = ent_vld[i] && (ent_vpn[i] == lk_vpn);
    assign fill_match[i]  = ent_vld[i] && (ent_vpn[i] == fill_vpn);
    assign inval_match[i] = ent_vld[i] && (ent_vpn[i] == inval_vpn);
    assign alloc_here[i]  = fill_valid && !fill_any && (rr_ptr == IDX_W'(i));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ent_vld[i] <= 1'b0;
        ent_vpn[i] <= '0;
        ent_pte[i] <= '0;
      end else if (inval_valid && inval_match[i]) begin
        ent_vld[i] <= 1'b0;
        ent_pte[i] <= '0;
      end else if ((fill_valid && fill_match[i]) || alloc_here[i]) begin
        ent_vld[i] <= 1'b1;
        ent_vpn[i] <= fill_vpn;
        ent_pte[i] <= merge_pte(fill_pte, fill_match[i] && ent_pte[i][ISO_BIT]);
      end
    end

    // R8
    sticky_iso_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ent_vld[i] && ent_pte[i][ISO_BIT] && !(inval_valid && inval_match[i])
       && !alloc_here[i]) |=> (ent_vld[i] && ent_pte[i][ISO_BIT]));

    // R9
    unmap_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (inval_valid && inval_match[i]) |=> !ent_vld[i]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                      rr_ptr <= '0;
    else if (fill_valid && !fill_any) rr_ptr <= (rr_ptr == IDX_W'(ENTRIES-1)) ? '0 : rr_ptr + 1'b1;
  end

  always_comb begin
    lk_pte = '0;
    for (int k = 0; k < ENTRIES; k++)
      if (lk_match[k]) lk_pte = lk_pte | ent_pte[k];
  end
  assign lk_hit = |lk_match;

  // R10
  single_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_match));
endmodule

// File: rtl/iso_perm_check.sv
module iso_perm_check
  import iso_guard_pkg::*;
#(
  parameter int PA_W       = 52,
  parameter int PAGE_SHIFT = 12
) (
  input  logic                  hit,
  input  logic [PTE_W-1:0]      pte,
  input  logic                  secure,
  input  logic                  store,
  input  logic [PAGE_SHIFT-1:0] offset,
  output fault_e                fault,
  output logic [PA_W-1:0]       paddr
);
  fault_e verdict;
  assign verdict = judge(pte, secure, store);
  assign fault   = hit ? verdict : FLT_NONE;
  assign paddr   = (hit && verdict == FLT_NONE)
                   ? {pte[PA_W-1:PAGE_SHIFT], offset} : '0;
endmodule

// File: rtl/iso_access_guard.sv
module iso_access_guard
  import iso_guard_pkg::*;
#(
  parameter int VA_W       = 48,
  parameter int PA_W       = 52,
  parameter int PAGE_SHIFT = 12,
  parameter int ENTRIES    = 8,
  localparam int VPN_W     = VA_W - PAGE_SHIFT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic             req_store,
  input  logic             req_secure,
  input  logic             fill_valid,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [63:0]      fill_pte,
  input  logic             inval_valid,
  input  logic [VPN_W-1:0] inval_vpn,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic [PA_W-1:0]  rsp_paddr,
  output logic [1:0]       rsp_fault
);
  logic             lk_hit;
  logic [PTE_W-1:0] lk_pte;
  fault_e           chk_fault;
  logic [PA_W-1:0]  chk_paddr;

  iso_xlat_cache #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) u_cache (
    .clk(clk), .rst_n(rst_n),
    .lk_vpn(req_vaddr[VA_W-1:PAGE_SHIFT]), .lk_hit(lk_hit), .lk_pte(lk_pte),
    .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_pte(fill_pte),
    .inval_valid(inval_valid), .inval_vpn(inval_vpn)
  );

  iso_perm_check #(.PA_W(PA_W), .PAGE_SHIFT(PAGE_SHIFT)) u_check (
    .hit(lk_hit), .pte(lk_pte), .secure(req_secure), .store(req_store),
    .offset(req_vaddr[PAGE_SHIFT-1:0]), .fault(chk_fault), .paddr(chk_paddr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_paddr <= '0;
      rsp_fault <= 2'b00;
    end else begin
      rsp_valid <= req_valid;
      rsp_hit   <= req_valid && lk_hit;
      rsp_paddr <= req_valid ? chk_paddr : '0;
      rsp_fault <= req_valid ? chk_fault : FLT_NONE;
    end
  end

  // R1
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  // R1
  rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  // R2
  miss_no_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (rsp_fault == 2'b00 && rsp_paddr == '0));
  // R3
  fault_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_fault != 2'b00) |-> (rsp_paddr == '0 && rsp_hit));
endmodule

// File: tb/test_iso_access_guard.sv
module test_iso_access_guard;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_store, req_secure;
  logic [47:0] req_vaddr;
  logic        fill_valid, inval_valid;
  logic [35:0] fill_vpn, inval_vpn;
  logic [63:0] fill_pte;
  logic        rsp_valid, rsp_hit;
  logic [51:0] rsp_paddr;
  logic [1:0]  rsp_fault;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  iso_access_guard i_iso_access_guard (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_vaddr(req_vaddr), .req_store(req_store),
    .req_secure(req_secure),
    .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_pte(fill_pte),
    .inval_valid(inval_valid), .inval_vpn(inval_vpn),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_paddr(rsp_paddr),
    .rsp_fault(rsp_fault)
  );

  function automatic logic [63:0] mk_pte(input logic [39:0] frame, input logic iso,
                                         input logic wr, input logic pres);
    return {11'd0, iso, frame, 10'd0, wr, pres};
  endfunction

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; req_valid = 0; req_store = 0; req_secure = 0; req_vaddr = '0;
    fill_valid = 0; fill_vpn = '0; fill_pte = '0; inval_valid = 0; inval_vpn = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic fill(input logic [35:0] vpn, input logic [63:0] pte);
    @(negedge clk);
    fill_valid = 1; fill_vpn = vpn; fill_pte = pte;
    @(negedge clk);
    fill_valid = 0;
  endtask

  task automatic unmap(input logic [35:0] vpn);
    @(negedge clk);
    inval_valid = 1; inval_vpn = vpn;
    @(negedge clk);
    inval_valid = 0;
  endtask

  // one request; response read half a cycle after the registering edge
  task automatic access(input string req, input logic [35:0] vpn, input logic [11:0] off,
                        input logic st, input logic sec, input logic exp_hit,
                        input logic [1:0] exp_flt, input logic [51:0] exp_pa);
    @(negedge clk);
    req_valid = 1; req_vaddr = {vpn, off}; req_store = st; req_secure = sec;
    @(negedge clk);
    req_valid = 0;
    chk({req, " valid"}, 64'(rsp_valid), 64'd1);
    chk({req, " hit"},   64'(rsp_hit),   64'(exp_hit));
    chk({req, " fault"}, 64'(rsp_fault), 64'(exp_flt));
    chk({req, " paddr"}, 64'(rsp_paddr), 64'(exp_pa));
  endtask

  task automatic t_reset();
    do_reset();
    @(negedge clk);
    chk("R11 idle valid", 64'(rsp_valid), 64'd0);
    access("R11 empty cache", 36'h5, 12'h10, 0, 0, 0, 2'b00, 52'd0);
  endtask

  task automatic t_basic();
    fill(36'h10, mk_pte(40'hAA, 0, 1, 1));
    fill(36'h20, mk_pte(40'hBB, 1, 1, 1));
    access("R5 plain load",  36'h10, 12'h123, 0, 0, 1, 2'b00, {40'hAA, 12'h123});
    access("R5 plain store", 36'h10, 12'hFFF, 1, 0, 1, 2'b00, {40'hAA, 12'hFFF});
    access("R5 secure store iso", 36'h20, 12'h004, 1, 1, 1, 2'b00, {40'hBB, 12'h004});
    access("R3 plain on iso", 36'h20, 12'h004, 0, 0, 1, 2'b01, 52'd0);
    access("R4 secure on plain", 36'h10, 12'h8, 1, 1, 1, 2'b10, 52'd0);
    access("R2 miss", 36'h30, 12'h0, 0, 0, 0, 2'b00, 52'd0);
  endtask

  task automatic t_std();
    fill(36'h40, mk_pte(40'hC1, 0, 0, 1));
    fill(36'h41, mk_pte(40'hC2, 0, 1, 0));
    fill(36'h42, mk_pte(40'hC3, 1, 0, 0));
    access("R6 store readonly", 36'h40, 12'h1, 1, 0, 1, 2'b11, 52'd0);
    access("R6 load readonly ok", 36'h40, 12'h1, 0, 0, 1, 2'b00, {40'hC1, 12'h1});
    access("R6 not present", 36'h41, 12'h2, 0, 0, 1, 2'b11, 52'd0);
    access("R7 iso beats std", 36'h42, 12'h3, 1, 0, 1, 2'b01, 52'd0);
    access("R7 secure no-present", 36'h42, 12'h3, 1, 1, 1, 2'b11, 52'd0);
    access("R7 sec on plain beats std", 36'h40, 12'h3, 1, 1, 1, 2'b10, 52'd0);
  endtask

  task automatic t_sticky();
    fill(36'h50, mk_pte(40'hD0, 1, 1, 1));
    fill(36'h50, mk_pte(40'hD9, 0, 1, 1));
    access("R8 mark kept", 36'h50, 12'h7, 0, 0, 1, 2'b01, 52'd0);
    access("R8 frame updated", 36'h50, 12'h7, 0, 1, 1, 2'b00, {40'hD9, 12'h7});
    unmap(36'h50);
    access("R9 unmapped miss", 36'h50, 12'h7, 0, 1, 0, 2'b00, 52'd0);
    fill(36'h50, mk_pte(40'hDA, 0, 1, 1));
    access("R9 refill plain", 36'h50, 12'h7, 0, 0, 1, 2'b00, {40'hDA, 12'h7});
  endtask

  task automatic t_b2b();
    fill(36'h60, mk_pte(40'hE0, 0, 1, 1));
    @(negedge clk);
    req_valid = 1; req_vaddr = {36'h60, 12'h11}; req_store = 0; req_secure = 0;
    @(negedge clk);
    req_vaddr = {36'h60, 12'h22}; req_secure = 1;
    chk("R1 first valid", 64'(rsp_valid), 64'd1);
    chk("R1 first paddr", 64'(rsp_paddr), 64'({40'hE0, 12'h11}));
    @(negedge clk);
    req_valid = 0;
    chk("R1 second valid", 64'(rsp_valid), 64'd1);
    chk("R1 second fault", 64'(rsp_fault), 64'd2);
    @(negedge clk);
    chk("R1 idle after", 64'(rsp_valid), 64'd0);
  endtask

  task automatic t_rr();
    do_reset();
    for (int i = 0; i < 9; i++) fill(36'h100 + 36'(i), mk_pte(40'h200 + 40'(i), 0, 1, 1));
    access("R10 oldest evicted", 36'h100, 12'h0, 0, 0, 0, 2'b00, 52'd0);
    access("R10 second kept", 36'h101, 12'h0, 0, 0, 1, 2'b00, {40'h201, 12'h0});
    access("R10 ninth present", 36'h108, 12'h5, 0, 0, 1, 2'b00, {40'h208, 12'h5});
  endtask

  initial begin
    t_reset();
    t_basic();
    t_std();
    t_sticky();
    t_b2b();
    t_rr();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule